// File: doc/BRIEF.md
# Pipelined Single-Port SRAM with Selectable Output Turn-Off

This block models a synchronous single-port memory whose reads pass through two register stages: a command stage that captures the request, and an output stage that holds the word read from the array. Each word is four 9-bit bytes. A request arrives each clock as a command enable, an address, two write controls and write data. Byte lanes are chosen by a whole-word write strobe or by a byte-write strobe together with per-byte selects. After the first word of a run of reads, a new word appears every clock.

The read-data drive enable stands in for a tristate pad. A static mode pin picks when the drive stops after a deselect. In early turn-off mode the drive stops as soon as the deselect reaches the command stage. In late turn-off mode it stops one stage later, together with the read data. An output-enable pin and a sleep pin gate the drive without waiting for the clock. Sleep also makes the command stage ignore new requests. The array keeps its contents throughout.

The control is a pipeline of command kinds, used as a two-stage state machine. Each stage holds one of three states: `DESEL`, `READ` or `WRITE`. On every edge the command stage takes the decoded request, and the output stage takes the command stage's previous state. The transitions are:
- load-read: a read moves into `READ`.
- load-write: a write moves into `WRITE`.
- deselect: no command, or sleep, moves into `DESEL`.
- advance: the output stage copies the command stage.

Top module: `pipe_sram`

## Requirements
- R1: After reset `rdata_en` is 0 and `rdata` is 0.
- R2: A read is a clock edge with `cmd_en`=1, `wr_all`=0, `wr_bytes`=0 and `sleep`=0. Its word and `rdata_en`=1 appear after the next edge, so the latency is two edges. Back-to-back reads give one word per cycle.
- R3: With `dual_desel`=0, a deselect (`cmd_en`=0) captured at an edge drops `rdata_en` right after that edge, even when a read word sits in the output stage.
- R4: With `dual_desel`=1, a read word followed by a deselect stays driven for the whole cycle after the deselect's edge. The drive drops after the following edge.
- R5: A request with `wr_all`=1 writes all four bytes, whatever `wr_bytes` and `byte_sel` are. Byte i is `wdata[9i+8:9i]`.
- R6: A request with `wr_all`=0 and `wr_bytes`=1 writes only the bytes i with `byte_sel[i]`=1. With `byte_sel`=0 the word is unchanged.
- R7: In the cycle after a write is captured, `rdata_en` is 0 even when a read word is in the output stage.
- R8: `oe`=0 forces `rdata_en` to 0 at once, with no clock edge needed. Raising `oe` again restores it.
- R9: `sleep`=1 forces `rdata_en` to 0 at once. Requests captured while `sleep`=1 are ignored, and the array contents are kept.
- R10: A read captured on the edge right after a write to the same address returns the new word, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dual_desel | input | 1 | 1: late (two-stage) turn-off, 0: early turn-off |
| sleep | input | 1 | Sleep: drive off, requests ignored |
| oe | input | 1 | Asynchronous output enable |
| cmd_en | input | 1 | Command enable; 0 is a deselect |
| wr_all | input | 1 | Whole-word write strobe |
| wr_bytes | input | 1 | Byte-gated write strobe |
| byte_sel | input | NB (4) | Per-byte write selects |
| addr | input | AW (6) | Word address |
| wdata | input | NB*BW (36) | Write data |
| rdata | output | NB*BW (36) | Read data from the output register |
| rdata_en | output | 1 | Drive enable for `rdata` |

## Verification
A read's word and drive enable are due two falling edges after the read is driven: one edge captures the command, the next loads the output register. A deselect driven after a read is visible one falling edge later in early mode and two falling edges later in late mode. The write-quiet cycle falls one falling edge after the write is driven. The bench drives every input on a falling edge and samples before it drives, so each check counts exactly the rising edges between stimulus and result. The effects of `oe` and `sleep` are checked within a single cycle, a few nanoseconds after the pin moves and before any rising edge.

// File: rtl/psr_pkg.sv
package psr_pkg;
    typedef enum logic [1:0] {
        K_DESEL = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2
    } kind_t;
endpackage

// File: rtl/psr_cmd_reg.sv
module psr_cmd_reg
    import psr_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             cmd_en,
    input  logic             wr_all,
    input  logic             wr_bytes,
    input  logic [NB-1:0]    byte_sel,
    input  logic [AW-1:0]    addr,
    input  logic [NB*BW-1:0] wdata,
    output kind_t            kind1,
    output logic [AW-1:0]    addr1,
    output logic [NB*BW-1:0] wdata1,
    output logic [NB-1:0]    mask1
);
    kind_t         kind_n;
    logic [NB-1:0] mask_n;

    // request decode: sleep and a cleared enable both become a deselect
    always_comb begin
        if (sleep || !cmd_en)        kind_n = K_DESEL;
        else if (wr_all || wr_bytes) kind_n = K_WRITE;
        else                         kind_n = K_READ;
        mask_n = wr_all ? {NB{1'b1}} : byte_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind1  <= K_DESEL;
            addr1  <= '0;
            wdata1 <= '0;
            mask1  <= '0;
        end else begin
            kind1  <= kind_n;
            addr1  <= addr;
            wdata1 <= wdata;
            mask1  <= mask_n;
        end
    end
endmodule

// File: rtl/psr_store.sv
module psr_store
    import psr_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  kind_t            kind1,
    input  logic [AW-1:0]    addr1,
    input  logic [NB*BW-1:0] wdata1,
    input  logic [NB-1:0]    mask1,
    output logic [NB*BW-1:0] rdata_q
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [BW-1:0] lane_mem [DEPTH];
        logic [BW-1:0] lane_q;

        // one storage column per byte lane
        always_ff @(posedge clk) begin
            if (kind1 == K_WRITE && mask1[g])
                lane_mem[addr1] <= wdata1[g*BW +: BW];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                lane_q <= '0;
            else if (kind1 == K_READ)  lane_q <= lane_mem[addr1];
        end

        assign rdata_q[g*BW +: BW] = lane_q;
    end
endmodule

// File: rtl/psr_drive.sv
module psr_drive
    import psr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  kind_t kind1,
    input  logic  dual_desel,
    input  logic  oe,
    input  logic  sleep,
    output logic  rdata_en
);
    kind_t kind2;
    logic  stage_ok;

    // output-stage state: advance from the command stage every edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) kind2 <= K_DESEL;
        else        kind2 <= kind1;
    end

    // drive decision from the pair of stage states
    always_comb begin
        stage_ok = 1'b0;
        unique case (kind2)
            K_READ: begin
                unique case (kind1)
                    K_WRITE: stage_ok = 1'b0;
                    K_DESEL: stage_ok = dual_desel;
                    default: stage_ok = 1'b1;
                endcase
            end
            default: stage_ok = 1'b0;
        endcase
    end

    assign rdata_en = stage_ok & oe & ~sleep;

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (kind1 == K_WRITE) |-> !rdata_en); // R7
    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rdata_en); // R9
    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !rdata_en); // R8
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
    import psr_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dual_desel,
    input  logic             sleep,
    input  logic             oe,
    input  logic             cmd_en,
    input  logic             wr_all,
    input  logic             wr_bytes,
    input  logic [NB-1:0]    byte_sel,
    input  logic [AW-1:0]    addr,
    input  logic [NB*BW-1:0] wdata,
    output logic [NB*BW-1:0] rdata,
    output logic             rdata_en
);
    localparam int WW = NB * BW;

    kind_t         kind1;
    logic [AW-1:0] addr1;
    logic [WW-1:0] wdata1;
    logic [NB-1:0] mask1;

    psr_cmd_reg #(.AW(AW), .NB(NB), .BW(BW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .cmd_en(cmd_en),
        .wr_all(wr_all), .wr_bytes(wr_bytes), .byte_sel(byte_sel),
        .addr(addr), .wdata(wdata),
        .kind1(kind1), .addr1(addr1), .wdata1(wdata1), .mask1(mask1)
    );

    psr_store #(.AW(AW), .NB(NB), .BW(BW)) u_store (
        .clk(clk), .rst_n(rst_n), .kind1(kind1), .addr1(addr1),
        .wdata1(wdata1), .mask1(mask1), .rdata_q(rdata)
    );

    psr_drive u_drive (
        .clk(clk), .rst_n(rst_n), .kind1(kind1), .dual_desel(dual_desel),
        .oe(oe), .sleep(sleep), .rdata_en(rdata_en)
    );

    // port-level view of requests, for the timing properties below
    logic       acc_rd, acc_wr, acc_des;
    logic [1:0] age;
    assign acc_rd  = !sleep && cmd_en && !wr_all && !wr_bytes;
    assign acc_wr  = !sleep && cmd_en && (wr_all || wr_bytes);
    assign acc_des = sleep || !cmd_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_SCD_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_desel && age >= 2'd1 && $past(acc_des)) |-> !rdata_en); // R3
    AST_DCD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_desel && age >= 2'd2 && $past(acc_rd, 2) && !$past(acc_wr)
         && oe && !sleep) |-> rdata_en); // R4
endmodule

// File: tb/sim_pipe_sram.sv
module sim_pipe_sram;
    logic        clk = 1'b0;
    logic        rst_n, dual_desel, sleep, oe, cmd_en, wr_all, wr_bytes;
    logic [3:0]  byte_sel;
    logic [5:0]  addr;
    logic [35:0] wdata, rdata;
    logic        rdata_en;
    logic [35:0] ref_mem [64];
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    pipe_sram u0 (
        .clk(clk), .rst_n(rst_n), .dual_desel(dual_desel), .sleep(sleep),
        .oe(oe), .cmd_en(cmd_en), .wr_all(wr_all), .wr_bytes(wr_bytes),
        .byte_sel(byte_sel), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_en(rdata_en)
    );

    function automatic logic [35:0] lane_mask(input logic [3:0] bs);
        logic [35:0] m;
        for (int i = 0; i < 4; i++) m[i*9 +: 9] = {9{bs[i]}};
        return m;
    endfunction

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic wa, input logic wb,
                        input logic [3:0] bs, input logic [5:0] a, input logic [35:0] d);
        cmd_en = en; wr_all = wa; wr_bytes = wb; byte_sel = bs; addr = a; wdata = d;
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, 4'h0, 6'd0, 36'h0);
    endtask

    task automatic put(input logic [5:0] a, input logic [35:0] d, input logic [3:0] bs,
                       input logic wa, input logic wb);
        step(1'b1, wa, wb, bs, a, d);
        if (wa)      ref_mem[a] = d;
        else if (wb) ref_mem[a] = (d & lane_mask(bs)) | (ref_mem[a] & ~lane_mask(bs));
    endtask

    task automatic read_one(input logic [5:0] a, input string tag);
        step(1'b1, 1'b0, 1'b0, 4'h0, a, 36'h0);
        idle();
        check({tag, " en"}, {35'b0, rdata_en}, 36'd1);
        check({tag, " data"}, rdata, ref_mem[a]);
        idle();
    endtask

    task automatic t_reset();
        check("R1 en", {35'b0, rdata_en}, 36'd0);
        check("R1 data", rdata, 36'h0);
    endtask

    task automatic t_whole_write();
        put(6'd3, 36'h1_2345_6789, 4'h0, 1'b1, 1'b0);
        put(6'd4, 36'hA_BCDE_F012, 4'h1, 1'b1, 1'b1);
        idle();
        read_one(6'd3, "R5 word3");
        read_one(6'd4, "R5 word4 ignores byte_sel");
    endtask

    task automatic t_byte_write();
        put(6'd5, 36'hF_FFFF_FFFF, 4'h0, 1'b1, 1'b0);
        put(6'd5, 36'h0_0000_0000, 4'h5, 1'b0, 1'b1);
        idle();
        read_one(6'd5, "R6 lanes 0,2");
        check("R6 expected pattern", ref_mem[5], 36'hF_F803_FE00);
        put(6'd5, 36'h0_0000_0000, 4'h0, 1'b0, 1'b1);
        idle();
        read_one(6'd5, "R6 no lanes");
    endtask

    task automatic t_burst(input logic dual);
        logic exp_en;
        dual_desel = dual;
        for (int k = 0; k < 4; k++) put(6'(8 + k), 36'h3_0000_0000 + 36'(k * 36'h1111), 4'h0, 1'b1, 1'b0);
        idle();
        for (int j = 0; j < 7; j++) begin
            if (j >= 2 && j <= 4) exp_en = 1'b1;
            else if (j == 5)      exp_en = dual;
            else                  exp_en = 1'b0;
            if (j == 5) check(dual ? "R4 held after deselect" : "R3 cut at deselect",
                              {35'b0, rdata_en}, {35'b0, exp_en});
            else        check("R2 burst enable", {35'b0, rdata_en}, {35'b0, exp_en});
            if (exp_en) check("R2 burst data", rdata, ref_mem[8 + j - 2]);
            if (j < 4) step(1'b1, 1'b0, 1'b0, 4'h0, 6'(8 + j), 36'h0);
            else       idle();
        end
        dual_desel = 1'b1;
    endtask

    task automatic t_write_quiet();
        step(1'b1, 1'b0, 1'b0, 4'h0, 6'd8, 36'h0);
        put(6'd12, 36'h5_5555_5555, 4'h0, 1'b1, 1'b0);
        check("R7 quiet after write", {35'b0, rdata_en}, 36'd0);
        idle();
        idle();
        read_one(6'd12, "R7 written word");
    endtask

    task automatic t_raw();
        put(6'd20, 36'h9_8765_4321, 4'h0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 4'h0, 6'd20, 36'h0);
        idle();
        check("R10 en", {35'b0, rdata_en}, 36'd1);
        check("R10 new word", rdata, 36'h9_8765_4321);
        idle();
    endtask

    task automatic t_oe();
        step(1'b1, 1'b0, 1'b0, 4'h0, 6'd9, 36'h0);
        idle();
        check("R8 driven", {35'b0, rdata_en}, 36'd1);
        #2 oe = 1'b0;
        #1 check("R8 oe low", {35'b0, rdata_en}, 36'd0);
        #1 oe = 1'b1;
        #1 check("R8 oe back", {35'b0, rdata_en}, 36'd1);
        @(negedge clk);
        idle();
    endtask

    task automatic t_sleep();
        step(1'b1, 1'b0, 1'b0, 4'h0, 6'd10, 36'h0);
        idle();
        check("R9 driven", {35'b0, rdata_en}, 36'd1);
        #2 sleep = 1'b1;
        #1 check("R9 sleep off", {35'b0, rdata_en}, 36'd0);
        @(negedge clk);
        step(1'b1, 1'b1, 1'b0, 4'h0, 6'd10, 36'h0_0BAD_0BAD);
        step(1'b1, 1'b0, 1'b0, 4'h0, 6'd10, 36'h0);
        idle();
        check("R9 read ignored", {35'b0, rdata_en}, 36'd0);
        sleep = 1'b0;
        idle();
        read_one(6'd10, "R9 contents kept");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; dual_desel = 1'b1; sleep = 1'b0; oe = 1'b1;
        cmd_en = 1'b0; wr_all = 1'b0; wr_bytes = 1'b0; byte_sel = 4'h0;
        addr = 6'd0; wdata = 36'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_whole_write();
        t_byte_write();
        t_burst(1'b1);
        t_burst(1'b0);
        t_write_quiet();
        t_raw();
        t_oe();
        t_sleep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule